// File: doc/BRIEF.md
# Packing Block-Transfer Bus Engine

This engine copies a run of 16-bit words between a local word-addressed buffer and a narrower external peripheral bus. A single 3-bit operation code chooses the direction and how each memory word is split on the bus. In the output direction a memory word goes out as one whole-word beat, two byte beats or four nibble beats. In the input direction one or two bus reads are packed into each memory word. Both the buffer and the bus are walked from the highest address downward.

A client loads the operation code, a word count, a bus base address, a buffer base address, a bus control word and a per-beat wait length, then pulses `start`. The engine presents the control word once. It then alternates one-cycle memory accesses with bus beats until the count is used up, and pulses `done`. Each bus beat holds `bus_strobe` high for the programmed number of wait cycles.

Top module: `blkxfer_engine`

## Requirements
- R1: `op[2]` selects the direction (0: memory to bus, 1: bus to memory) and `op[1:0]` selects the size (0 word, 1 byte, 2 byte-swapped, 3 nibble). Code 7 is not a legal operation, and a `start` carrying it leaves the engine idle. A `start` that arrives while `busy` is high is ignored and does not alter the transfer in progress.
- R2: The first bus beat uses address `bus_base + count*k - 1`, where k is 1 for word, 2 for byte sizes and 4 for nibble. Every following beat uses an address one lower than the beat before it.
- R3: Memory words are accessed from `buf_base + count - 1` down to `buf_base`, one memory access per cycle. Memory read, memory write and bus strobe are never active together.
- R4: Word output (code 0) drives each memory word unchanged as one beat.
- R5: Byte output (code 1) drives bits [7:0] of the word and then bits [15:8]. Byte-swapped output (code 2) drives bits [15:8] first and then bits [7:0]. Bits [15:8] of `bus_wdata` are zero on byte beats.
- R6: Nibble output (code 3) drives four beats per word carrying bits [3:0], [7:4], [11:8] and [15:12] in that order. Bits [15:4] of `bus_wdata` are zero on these beats.
- R7: Word input (code 4) writes all 16 bits of one bus read into one memory word.
- R8: Byte input (codes 5 and 6) takes bits [7:0] of two bus reads per memory word, ignoring bits [15:8]. For code 5 the first read lands in bits [7:0] and the second in bits [15:8]. For code 6 the first read lands in bits [15:8] and the second in bits [7:0].
- R9: `bus_ctl_we` pulses for one cycle with `bus_ctl` equal to the loaded control word. This happens after `start` and before the first beat or memory access.
- R10: Each beat keeps `bus_strobe` high for `wait_cycles` cycles, or for 1 cycle when `wait_cycles` is 0. Input data is sampled in the last of those cycles.
- R11: A count of zero still presents the control word and signals completion, but performs no bus beat and no memory access.
- R12: After reset `busy`, `done`, `bus_strobe`, `mem_rd` and `mem_wr` are low. `done` is high for exactly one cycle, in the cycle after the final beat or memory write. `busy` is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted only while idle |
| op | input | 3 | Operation code (direction and size) |
| count | input | CW | Number of memory words to move |
| bus_base | input | AW | Bus base address |
| buf_base | input | MAW | Buffer base address |
| ctl_word | input | 16 | Bus control word |
| wait_cycles | input | WW | Strobe length per beat (0 treated as 1) |
| mem_addr | output | MAW | Memory word address |
| mem_rd | output | 1 | Memory read, data returned the next cycle |
| mem_rdata | input | 16 | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| bus_ctl | output | 16 | Latched bus control word |
| bus_ctl_we | output | 1 | Control word present pulse |
| bus_addr | output | AW | Bus beat address |
| bus_dir | output | 1 | 1 when the engine drives bus data |
| bus_strobe | output | 1 | Bus beat active |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle: memory and bus activity stay mutually exclusive, and the control pulse never coincides with a beat or memory read. Strobes only occur while busy, `done` is a lone pulse followed by idle, an illegal code leaves the engine idle, and successive beat addresses within one run step down by exactly one. Other behaviour can only be shown by the bench scenarios. These include the exact data on every beat for each size and ordering, the packed words written back on input, the start addresses derived from the count, the total strobe length against the wait setting, and the absence of effect from a start issued mid-transfer.

// File: rtl/blkxfer_engine.sv
module blkxfer_engine #(
  parameter int AW  = 16,
  parameter int MAW = 16,
  parameter int CW  = 16,
  parameter int WW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [CW-1:0]  count,
  input  logic [AW-1:0]  bus_base,
  input  logic [MAW-1:0] buf_base,
  input  logic [15:0]    ctl_word,
  input  logic [WW-1:0]  wait_cycles,
  output logic [MAW-1:0] mem_addr,
  output logic           mem_rd,
  input  logic [15:0]    mem_rdata,
  output logic           mem_wr,
  output logic [15:0]    mem_wdata,
  output logic [15:0]    bus_ctl,
  output logic           bus_ctl_we,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_dir,
  output logic           bus_strobe,
  output logic [15:0]    bus_wdata,
  input  logic [15:0]    bus_rdata,
  output logic           busy,
  output logic           done
);
  typedef enum logic [2:0] {S_IDLE, S_CTL, S_MRD, S_MDAT, S_BEAT, S_MWR, S_FIN} st_t;

  st_t            st;
  logic [2:0]     opr;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  baddr;
  logic [MAW-1:0] maddr;
  logic [15:0]    sh, ctl_q;
  logic [WW-1:0]  wlen, wc;
  logic [1:0]     beat;

  wire [1:0]  sz      = opr[1:0];
  wire        dir_in  = opr[2];
  wire        last_bt = (sz == 2'd0) || (sz != 2'd3 && beat == 2'd1) || (beat == 2'd3);
  wire        wc_end  = (wc == wlen - WW'(1));
  wire [15:0] rin     = (sz == 2'd0) ? bus_rdata : {8'h00, bus_rdata[7:0]};
  wire [15:0] merged  = sh | rin;
  wire [1:0]  shamt   = (op[1:0] == 2'd0) ? 2'd0 : (op[1:0] == 2'd3) ? 2'd2 : 2'd1;

  function automatic logic [15:0] rot8(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [15:0] rot12(input logic [15:0] v);
    return {v[3:0], v[15:4]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      opr   <= '0;
      cnt   <= '0;
      baddr <= '0;
      maddr <= '0;
      sh    <= '0;
      ctl_q <= '0;
      wlen  <= WW'(1);
      wc    <= '0;
      beat  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && op != 3'd7) begin
          opr   <= op;
          cnt   <= count;
          baddr <= bus_base + (AW'(count) << shamt) - AW'(1);
          maddr <= buf_base + MAW'(count) - MAW'(1);
          wlen  <= (wait_cycles == '0) ? WW'(1) : wait_cycles;
          ctl_q <= ctl_word;
          st    <= S_CTL;
        end
        S_CTL: begin
          sh   <= '0;
          beat <= '0;
          wc   <= '0;
          if (cnt == '0)  st <= S_FIN;
          else if (dir_in) st <= S_BEAT;
          else            st <= S_MRD;
        end
        S_MRD: st <= S_MDAT;
        S_MDAT: begin
          sh   <= (sz == 2'd2) ? rot8(mem_rdata) : mem_rdata;
          beat <= '0;
          wc   <= '0;
          st   <= S_BEAT;
        end
        S_BEAT: begin
          if (!wc_end) begin
            wc <= wc + WW'(1);
          end else begin
            wc    <= '0;
            baddr <= baddr - AW'(1);
            if (dir_in) begin
              if (last_bt) begin
                sh <= (sz == 2'd1) ? rot8(merged) : merged;
                st <= S_MWR;
              end else begin
                sh   <= rot8(merged);
                beat <= beat + 2'd1;
              end
            end else if (last_bt) begin
              cnt   <= cnt - CW'(1);
              maddr <= maddr - MAW'(1);
              st    <= (cnt == CW'(1)) ? S_FIN : S_MRD;
            end else begin
              sh   <= (sz == 2'd3) ? rot12(sh) : rot8(sh);
              beat <= beat + 2'd1;
            end
          end
        end
        S_MWR: begin
          cnt   <= cnt - CW'(1);
          maddr <= maddr - MAW'(1);
          sh    <= '0;
          beat  <= '0;
          st    <= (cnt == CW'(1)) ? S_FIN : S_BEAT;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = maddr;
  assign mem_rd     = (st == S_MRD);
  assign mem_wr     = (st == S_MWR);
  assign mem_wdata  = sh;
  assign bus_ctl    = ctl_q;
  assign bus_ctl_we = (st == S_CTL);
  assign bus_addr   = baddr;
  assign bus_dir    = !opr[2];
  assign bus_strobe = (st == S_BEAT);
  assign bus_wdata  = (sz == 2'd0) ? sh : (sz == 2'd3) ? {12'h000, sh[3:0]} : {8'h00, sh[7:0]};
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
endmodule

// File: rtl/blkxfer_engine_chk.sv
module blkxfer_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    op,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          bus_ctl_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_strobe,
  input logic          busy,
  input logic          done
);
  p_illegal_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op == 3'd7) |=> !busy);

  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && $past(bus_strobe) && bus_addr != $past(bus_addr))
      |-> bus_addr == $past(bus_addr) - AW'(1));

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, bus_strobe}));

  p_ctl_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ctl_we |-> (!bus_strobe && !mem_rd && !mem_wr));

  p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> busy);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind blkxfer_engine blkxfer_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_ctl_we(bus_ctl_we),
  .bus_addr(bus_addr), .bus_strobe(bus_strobe), .busy(busy), .done(done)
);

// File: tb/blkxfer_engine_tb.sv
`timescale 1ns/1ps
module blkxfer_engine_tb;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [2:0]  op = 0;
  logic [15:0] count = 0, bus_base = 0, buf_base = 0, ctl_word = 0;
  logic [7:0]  wait_cycles = 0;
  logic [15:0] mem_addr, mem_wdata, bus_ctl, bus_addr, bus_wdata, bus_rdata;
  logic [15:0] mem_rdata = 0;
  logic        mem_rd, mem_wr, bus_ctl_we, bus_dir, bus_strobe, busy, done;

  always #5 clk = ~clk;

  blkxfer_engine u_dut (.*);

  logic [15:0] M [0:63];
  assign bus_rdata = {bus_addr[7:0] ^ 8'h5A, bus_addr[7:0] ^ 8'h3C};

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= M[mem_addr[5:0]];
    if (mem_wr) M[mem_addr[5:0]] <= mem_wdata;
  end

  int tests = 0, fails = 0;
  string cur_req = "R4";
  logic [31:0] beat_q[$];
  logic [31:0] wr_q[$];
  logic [15:0] exp_ctl;
  int n_beats, n_strobe, n_mem, n_done, n_ctl, n_ctl_bad;
  logic ps = 0;
  logic [15:0] pa = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_strobe) n_strobe++;
    if (mem_rd || mem_wr) n_mem++;
    if (done) n_done++;
    if (bus_ctl_we) begin
      n_ctl++;
      if (bus_ctl != exp_ctl || n_beats != 0 || n_mem != 0) n_ctl_bad++;
    end
    if (bus_strobe && (!ps || bus_addr != pa)) begin
      n_beats++;
      if (bus_dir) begin
        if (beat_q.size() == 0) chk(0, cur_req, {bus_addr, bus_wdata}, 32'hXXXXXXXX);
        else begin
          logic [31:0] e;
          e = beat_q.pop_front();
          chk({bus_addr, bus_wdata} === e, cur_req, {bus_addr, bus_wdata}, e);
        end
      end
    end
    if (mem_wr) begin
      if (wr_q.size() == 0) chk(0, cur_req, {mem_addr, mem_wdata}, 32'hXXXXXXXX);
      else begin
        logic [31:0] e;
        e = wr_q.pop_front();
        chk({mem_addr, mem_wdata} === e, cur_req, {mem_addr, mem_wdata}, e);
      end
    end
    ps = bus_strobe;
    pa = bus_addr;
  end

  function automatic logic [15:0] fr(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'h3C};
  endfunction

  task automatic run(input logic [2:0] o, input int n, input logic [15:0] bb, input logic [15:0] fb,
                     input logic [15:0] cw, input int wt, input string req, input bit poke);
    int k, wl, cyc;
    logic [15:0] a, w, b1, b2;
    k  = (o[1:0] == 0) ? 1 : (o[1:0] == 3) ? 4 : 2;
    wl = (wt == 0) ? 1 : wt;
    a  = bb + 16'(n * k) - 16'd1;
    for (int i = n - 1; i >= 0; i--) begin
      if (!o[2]) begin
        w = M[6'(fb + 16'(i))];
        if (o[1:0] == 2) w = {w[7:0], w[15:8]};
        for (int j = 0; j < k; j++) begin
          if (j > 0) w = (o[1:0] == 3) ? {w[3:0], w[15:4]} : {w[7:0], w[15:8]};
          beat_q.push_back({a, (k == 1) ? w : (k == 4) ? {12'h0, w[3:0]} : {8'h0, w[7:0]}});
          a = a - 16'd1;
        end
      end else if (k == 1) begin
        wr_q.push_back({fb + 16'(i), fr(a)});
        a = a - 16'd1;
      end else begin
        b1 = {8'h0, fr(a)[7:0]}; a = a - 16'd1;
        b2 = {8'h0, fr(a)[7:0]}; a = a - 16'd1;
        wr_q.push_back({fb + 16'(i), (o[1:0] == 1) ? ((b2 << 8) | b1) : ((b1 << 8) | b2)});
      end
    end
    @(posedge clk); #1;
    cur_req = req; exp_ctl = cw;
    n_beats = 0; n_strobe = 0; n_mem = 0; n_done = 0; n_ctl = 0; n_ctl_bad = 0;
    op = o; count = 16'(n); bus_base = bb; buf_base = fb; ctl_word = cw; wait_cycles = 8'(wt); start = 1;
    @(posedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1; op = 3'd0; count = 16'd9; bus_base = 16'h7000; ctl_word = 16'hDEAD; start = 1;
      @(posedge clk); #1; start = 0;
    end
    cyc = 0;
    while (n_done == 0 && cyc < 3000) begin @(posedge clk); #1; cyc++; end
    chk(cyc < 3000, {req, " watchdog"}, cyc, 3000);
    @(posedge clk); #1;
    chk(!busy && n_done == 1, "R12", {busy, 8'(n_done)}, 1);
    chk(beat_q.size() == 0 && wr_q.size() == 0, req, beat_q.size() + wr_q.size(), 0);
    chk(n_strobe == n * k * wl, "R10", n_strobe, n * k * wl);
    chk(n_ctl == 1 && n_ctl_bad == 0, "R9", {n_ctl, n_ctl_bad}, 1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) M[i] = 16'(i * 16'h1357 + 16'h2468);
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !bus_strobe && !mem_rd && !mem_wr, "R12",
        {busy, done, bus_strobe, mem_rd, mem_wr}, 0);
    rst_n = 1;
    run(3'd0, 3, 16'h0100, 16'd4,  16'hC001, 2, "R4", 0);
    run(3'd1, 2, 16'h0200, 16'd10, 16'hC002, 1, "R5", 0);
    run(3'd2, 2, 16'h0300, 16'd20, 16'hC003, 0, "R5", 0);
    run(3'd3, 2, 16'h0400, 16'd30, 16'hC004, 3, "R6", 0);
    run(3'd4, 3, 16'h0500, 16'd40, 16'hC005, 2, "R7", 0);
    run(3'd5, 2, 16'h0610, 16'd48, 16'hC006, 1, "R8", 0);
    run(3'd6, 2, 16'h0720, 16'd52, 16'hC007, 2, "R8", 0);
    run(3'd1, 3, 16'h0800, 16'd12, 16'hC008, 2, "R1", 1);
    run(3'd0, 4, 16'hFFF0, 16'd0,  16'hC009, 1, "R2", 0);
    run(3'd1, 0, 16'h0900, 16'd8,  16'hC00A, 2, "R11", 0);
    chk(n_mem == 0 && n_beats == 0, "R11", {n_mem, n_beats}, 0);
    @(posedge clk); #1;
    op = 3'd7; count = 16'd2; start = 1;
    @(posedge clk); #1; start = 0;
    repeat (4) begin
      chk(!busy && !bus_strobe && !mem_rd, "R1", {busy, bus_strobe, mem_rd}, 0);
      @(posedge clk); #1;
    end
    run(3'd4, 2, 16'h0A00, 16'd60, 16'hC00B, 0, "R3", 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule